// File: doc/BRIEF.md
# Nine-Bit Capable UART Core

This block is the serial engine of an asynchronous port. It serialises characters taken from a transmit queue and deserialises characters arriving on the receive line into a receive queue. Character format is set by static configuration inputs: 5 to 8 data bits, parity, one or two stop bits, and an optional ninth bit that marks a character as an address or as data. The bit clock comes from an integer divisor that produces a sample tick at sixteen times the bit rate.

Each received character is stored together with four status flags, so error information stays with the character it belongs to. Each queue is 16 entries deep, or a single holding slot when queuing is turned off. Three interrupt requests, each with its own enable, report receive fill level, transmit drain level and a receive timeout. The transmitter can hold the line low to send a break. The receiver recognises a break, and it rejects start bits that are only glitches.

Top module: `u9_uart`

## Requirements
- R1: The data field is 5, 6, 7 or 8 bits for `cfg_wlen` = 0, 1, 2, 3. It is sent least significant bit first after a low start bit. Transmit bits above the field are ignored, and received bits above the field read as zero.
- R2: `cfg_par` 00 selects no parity, 01 odd and 10 or 11 even. The parity bit follows the data field. A received parity mismatch sets entry bit 9.
- R3: When `cfg_stop2` is 1, two high stop bits are sent; otherwise one. The receiver checks only the first stop bit, and a low first stop bit sets entry bit 10.
- R4: When `cfg_nine` is 1, `tx_data[8]` is sent in the parity position and parity is not used. The received tag is returned in entry bit 9.
- R5: A receive entry is data in [7:0], break in bit 8, parity error or tag in bit 9, framing error in bit 10 and overrun in bit 11. `rx_data` shows the oldest entry.
- R6: Each queue holds 16 entries when `cfg_fifo_en` is 1 and one entry when it is 0. `tx_full` reports a full transmit queue.
- R7: A start bit that is high again at its eighth sample tick is discarded, and the receiver returns to idle.
- R8: While `cfg_break` is 1, `txd` is low from the next clock on. Otherwise an idle `txd` is high.
- R9: A frame whose samples are all low, stop bit included, gives one entry with bits 8 and 10 set. The receiver then waits for a high line before it looks for a new start bit.
- R10: `irq_rx` is high when `cfg_irq_en[0]` is set and the receive level exceeds `cfg_rx_trig`. The threshold is 0 when the queues are off.
- R11: `irq_tx` is high when `cfg_irq_en[1]` is set and the transmit level is at most `cfg_tx_trig`. The threshold is 0 when the queues are off.
- R12: `irq_rto` is high when `cfg_irq_en[2]` is set, the receive queue is not empty, and no character has arrived for 512 sample ticks (32 bit periods).
- R13: A character that arrives while the receive queue is full and not being read is dropped, and bit 11 is set on the newest stored entry.
- R14: A sample tick occurs every `cfg_div` clocks (0 counts as 1). A bit lasts 16 ticks, and the receiver takes each bit at its eighth tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_div | input | DIV_W | Clocks per sample tick |
| cfg_wlen | input | 2 | Data field length code |
| cfg_par | input | 2 | Parity mode |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_nine | input | 1 | Ninth-bit tag mode |
| cfg_fifo_en | input | 1 | Queues on (16 deep) or off (1 deep) |
| cfg_rx_trig | input | AW | Receive interrupt threshold |
| cfg_tx_trig | input | AW | Transmit interrupt threshold |
| cfg_break | input | 1 | Force line low |
| cfg_irq_en | input | 3 | Enables: 0 receive, 1 transmit, 2 timeout |
| tx_push | input | 1 | Write `tx_data` into transmit queue |
| tx_data | input | 9 | Character, bit 8 is the tag |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove oldest receive entry |
| rx_data | output | 12 | Oldest receive entry |
| rx_empty | output | 1 | Receive queue empty |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq_rx | output | 1 | Receive level request |
| irq_tx | output | 1 | Transmit level request |
| irq_rto | output | 1 | Receive timeout request |

## Verification
A wrong sample or shift count in the receiver shows as a corrupted or misflagged entry at `rx_data` within one frame of the bad cycle. A wrong transmit shift or length shows on `txd` as a bit sampled at a mid-bit point that differs from the expected value. Queue pointer or count faults appear as a missing entry, a wrong overrun flag, or a `tx_full` that disagrees with the push history, and they are visible as soon as the affected entry is read. Timeout counter faults move the `irq_rto` edge away from the 512-tick point, so they are seen within about one timeout interval.

// File: rtl/u9_pkg.sv
package u9_pkg;
    localparam int ENT_W = 12;
    localparam int TXE_W = 9;
    localparam int B_BRK = 8;
    localparam int B_PE  = 9;
    localparam int B_FE  = 10;
    localparam int B_OVR = 11;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_WAITHI} rx_st_e;

    function automatic int data_bits(input logic [1:0] wl);
        return 5 + int'(wl);
    endfunction
endpackage

// File: rtl/u9_fifo.sv
module u9_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          one_deep,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic [W-1:0]  mark,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] level
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } st_t;

    st_t q, d;
    logic          do_pop, do_push;
    logic [CW-1:0] lim;
    logic [AW-1:0] last;

    always_comb begin
        d       = q;
        lim     = one_deep ? CW'(1) : CW'(DEPTH);
        full    = (q.cnt >= lim);
        do_pop  = pop && (q.cnt != '0);
        do_push = push && (!full || do_pop);
        last    = q.wp - AW'(1);
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp        = q.wp + AW'(1);
        end else if (push) begin
            // dropped write: flag the newest stored entry
            d.mem[last] = q.mem[last] | mark;
        end
        if (do_pop) d.rp = q.rp + AW'(1);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    assign dout  = q.mem[q.rp];
    assign empty = (q.cnt == '0);
    assign level = q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/u9_tx.sv
module u9_tx
    import u9_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       cfg_wlen,
    input  logic [1:0]       cfg_par,
    input  logic             cfg_stop2,
    input  logic             cfg_nine,
    input  logic             cfg_break,
    input  logic             fifo_empty,
    input  logic [TXE_W-1:0] fifo_data,
    output logic             fifo_pop,
    output logic             txd
);
    localparam int FW = 12;

    typedef struct packed {
        logic          busy;
        logic [FW-1:0] sh;
        logic [3:0]    left;
        logic [3:0]    sub;
        logic          txd;
    } st_t;

    localparam st_t RST = '{busy: 1'b0, sh: '1, left: 4'd0, sub: 4'd0, txd: 1'b1};

    st_t           q, d;
    int            nb, len;
    logic          hx, xb;
    logic [7:0]    dm;
    logic [FW-1:0] frame;

    always_comb begin
        d        = q;
        fifo_pop = 1'b0;
        nb       = data_bits(cfg_wlen);
        hx       = cfg_nine | (cfg_par != 2'b00);
        dm       = '0;
        for (int i = 0; i < 8; i++) if (i < nb) dm[i] = fifo_data[i];
        xb       = cfg_nine ? fifo_data[8] : (cfg_par[1] ? ^dm : ~^dm);
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++) if (i < nb) frame[i+1] = dm[i];
        if (hx) frame[nb+1] = xb;
        len      = 2 + nb + int'(hx) + int'(cfg_stop2);

        if (!q.busy) begin
            if (!fifo_empty) begin
                d.busy   = 1'b1;
                d.sh     = frame;
                d.left   = 4'(len);
                d.sub    = '0;
                fifo_pop = 1'b1;
            end
        end else if (tick) begin
            if (q.sub == 4'd15) begin
                d.sub  = '0;
                d.sh   = {1'b1, q.sh[FW-1:1]};
                d.left = q.left - 4'd1;
                if (q.left == 4'd1) d.busy = 1'b0;
            end else begin
                d.sub = q.sub + 4'd1;
            end
        end
        d.txd = cfg_break ? 1'b0 : (d.busy ? d.sh[0] : 1'b1);
    end

    assign txd = q.txd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end
endmodule

// File: rtl/u9_rx.sv
module u9_rx
    import u9_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    input  logic [1:0]       cfg_wlen,
    input  logic [1:0]       cfg_par,
    input  logic             cfg_nine,
    output logic             ent_push,
    output logic [ENT_W-1:0] ent
);
    typedef struct packed {
        logic [1:0] sync;
        rx_st_e     st;
        logic [3:0] sub;
        logic [3:0] idx;
        logic [9:0] bits;
    } st_t;

    localparam st_t RST = '{sync: 2'b11, st: RX_IDLE, sub: 4'd0, idx: 4'd0, bits: 10'd0};

    st_t        q, d;
    logic       rxs, hx, xb, sb, allz, pe;
    logic [7:0] dv;
    int         nb, n;

    always_comb begin
        d        = q;
        d.sync   = {q.sync[0], rxd};
        rxs      = q.sync[1];
        ent_push = 1'b0;
        nb       = data_bits(cfg_wlen);
        hx       = cfg_nine | (cfg_par != 2'b00);
        n        = nb + int'(hx) + 1;

        case (q.st)
            RX_IDLE: if (tick && !rxs) begin
                d.st  = RX_START;
                d.sub = '0;
            end
            RX_START: if (tick) begin
                if (q.sub == 4'd7) begin
                    if (rxs) begin
                        d.st = RX_IDLE;
                    end else begin
                        d.st   = RX_DATA;
                        d.sub  = '0;
                        d.idx  = '0;
                        d.bits = '0;
                    end
                end else begin
                    d.sub = q.sub + 4'd1;
                end
            end
            RX_DATA: if (tick) begin
                if (q.sub == 4'd15) begin
                    d.sub         = '0;
                    d.bits[q.idx] = rxs;
                    d.idx         = q.idx + 4'd1;
                    if (int'(q.idx) == n - 1) begin
                        ent_push = 1'b1;
                        d.st     = rxs ? RX_IDLE : RX_WAITHI;
                    end
                end else begin
                    d.sub = q.sub + 4'd1;
                end
            end
            RX_WAITHI: if (rxs) d.st = RX_IDLE;
            default: d.st = RX_IDLE;
        endcase

        dv = '0;
        for (int i = 0; i < 8; i++) if (i < nb) dv[i] = d.bits[i];
        xb   = d.bits[nb];
        sb   = d.bits[nb + int'(hx)];
        allz = 1'b1;
        for (int i = 0; i < 10; i++) if (i < n && d.bits[i]) allz = 1'b0;
        pe   = cfg_nine ? xb : (hx && (xb != (cfg_par[1] ? ^dv : ~^dv)));

        ent        = '0;
        ent[7:0]   = dv;
        ent[B_BRK] = allz;
        ent[B_PE]  = pe;
        ent[B_FE]  = !sb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end
endmodule

// File: rtl/u9_uart.sv
module u9_uart
    import u9_pkg::*;
#(
    parameter int  FIFO_DEPTH = 16,
    parameter int  DIV_W      = 16,
    parameter int  TO_BITS    = 32,
    localparam int AW         = $clog2(FIFO_DEPTH),
    localparam int CW         = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       cfg_wlen,
    input  logic [1:0]       cfg_par,
    input  logic             cfg_stop2,
    input  logic             cfg_nine,
    input  logic             cfg_fifo_en,
    input  logic [AW-1:0]    cfg_rx_trig,
    input  logic [AW-1:0]    cfg_tx_trig,
    input  logic             cfg_break,
    input  logic [2:0]       cfg_irq_en,
    input  logic             tx_push,
    input  logic [TXE_W-1:0] tx_data,
    output logic             tx_full,
    input  logic             rx_pop,
    output logic [ENT_W-1:0] rx_data,
    output logic             rx_empty,
    input  logic             rxd,
    output logic             txd,
    output logic             irq_rx,
    output logic             irq_tx,
    output logic             irq_rto
);
    localparam int TO_TICKS = TO_BITS * 16;
    localparam int TW       = $clog2(TO_TICKS + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div_cnt;
        logic             tick;
        logic [TW-1:0]    to_cnt;
        logic             irq_rx;
        logic             irq_tx;
        logic             irq_rto;
    } st_t;

    st_t              q, d;
    logic             tx_pop, tx_empty, rx_push;
    logic [TXE_W-1:0] tx_head;
    logic [ENT_W-1:0] rx_ent, ovr_mark;
    logic [CW-1:0]    tx_lvl, rx_lvl, thr_rx, thr_tx;
    logic [DIV_W-1:0] div_last;

    always_comb begin
        ovr_mark        = '0;
        ovr_mark[B_OVR] = 1'b1;
    end

    u9_fifo #(.W(TXE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .one_deep(!cfg_fifo_en),
        .push(tx_push), .din(tx_data), .mark('0), .pop(tx_pop),
        .dout(tx_head), .empty(tx_empty), .full(tx_full), .level(tx_lvl)
    );

    u9_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(q.tick),
        .cfg_wlen(cfg_wlen), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .cfg_nine(cfg_nine), .cfg_break(cfg_break),
        .fifo_empty(tx_empty), .fifo_data(tx_head), .fifo_pop(tx_pop), .txd(txd)
    );

    u9_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(q.tick), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_par(cfg_par), .cfg_nine(cfg_nine),
        .ent_push(rx_push), .ent(rx_ent)
    );

    logic rx_full_unused;
    u9_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .one_deep(!cfg_fifo_en),
        .push(rx_push), .din(rx_ent), .mark(ovr_mark), .pop(rx_pop),
        .dout(rx_data), .empty(rx_empty), .full(rx_full_unused), .level(rx_lvl)
    );

    always_comb begin
        d        = q;
        div_last = (cfg_div == '0) ? '0 : cfg_div - DIV_W'(1);
        if (q.div_cnt >= div_last) begin
            d.div_cnt = '0;
            d.tick    = 1'b1;
        end else begin
            d.div_cnt = q.div_cnt + DIV_W'(1);
            d.tick    = 1'b0;
        end
        if (rx_push || rx_empty)                       d.to_cnt = '0;
        else if (q.tick && q.to_cnt != TW'(TO_TICKS))  d.to_cnt = q.to_cnt + TW'(1);
        thr_rx    = cfg_fifo_en ? {1'b0, cfg_rx_trig} : '0;
        thr_tx    = cfg_fifo_en ? {1'b0, cfg_tx_trig} : '0;
        d.irq_rx  = cfg_irq_en[0] && (rx_lvl > thr_rx);
        d.irq_tx  = cfg_irq_en[1] && (tx_lvl <= thr_tx);
        d.irq_rto = cfg_irq_en[2] && !rx_empty && (q.to_cnt == TW'(TO_TICKS));
    end

    assign irq_rx  = q.irq_rx;
    assign irq_tx  = q.irq_tx;
    assign irq_rto = q.irq_rto;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/u9_uart_chk.sv
module u9_uart_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_break,
    input logic          cfg_fifo_en,
    input logic          txd,
    input logic          rx_empty,
    input logic          irq_rx,
    input logic          irq_rto,
    input logic [CW-1:0] tx_lvl,
    input logic [CW-1:0] rx_lvl
);
    a_r8_break_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_break |=> !txd);

    a_r6_rx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lvl <= CW'(DEPTH));

    a_r6_tx_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fifo_en && tx_lvl <= CW'(1)) |=> (cfg_fifo_en || tx_lvl <= CW'(1)));

    a_r10_rx_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> $past(!rx_empty));

    a_r12_rto_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rto |-> $past(!rx_empty));
endmodule

bind u9_uart u9_uart_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_break(cfg_break), .cfg_fifo_en(cfg_fifo_en),
    .txd(txd), .rx_empty(rx_empty), .irq_rx(irq_rx), .irq_rto(irq_rto),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl)
);

// File: tb/u9_uart_tb.sv
module u9_uart_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd2;
    logic [1:0]  cfg_wlen = 2'd3;
    logic [1:0]  cfg_par = 2'd0;
    logic        cfg_stop2 = 1'b0;
    logic        cfg_nine = 1'b0;
    logic        cfg_fifo_en = 1'b1;
    logic [3:0]  cfg_rx_trig = 4'd0;
    logic [3:0]  cfg_tx_trig = 4'd0;
    logic        cfg_break = 1'b0;
    logic [2:0]  cfg_irq_en = 3'b000;
    logic        tx_push = 1'b0;
    logic [8:0]  tx_data = '0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [11:0] rx_data;
    logic        rx_empty;
    logic        rxd, txd, irq_rx, irq_tx, irq_rto;
    logic        lb = 1'b0;
    logic        rxd_drv = 1'b1;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    localparam int BIT = 32;  // clocks per bit at cfg_div = 2

    assign rxd = lb ? txd : rxd_drv;
    always #2.5 clk = ~clk;

    u9_uart u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_wlen(cfg_wlen),
        .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .cfg_nine(cfg_nine),
        .cfg_fifo_en(cfg_fifo_en), .cfg_rx_trig(cfg_rx_trig), .cfg_tx_trig(cfg_tx_trig),
        .cfg_break(cfg_break), .cfg_irq_en(cfg_irq_en), .tx_push(tx_push),
        .tx_data(tx_data), .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .rxd(rxd), .txd(txd), .irq_rx(irq_rx),
        .irq_tx(irq_tx), .irq_rto(irq_rto)
    );

    typedef struct packed {
        logic [1:0]  wl;
        logic [1:0]  par;
        logic        s2;
        logic        nine;
        logic [8:0]  dat;
        logic [3:0]  len;
        logic [11:0] frame;
        logic [11:0] ent;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'd3, 2'd0, 1'b0, 1'b0, 9'h0A5, 4'd10, 12'h34A, 12'h0A5},
        '{2'd0, 2'd2, 1'b1, 1'b0, 9'h013, 4'd9,  12'h1E6, 12'h013},
        '{2'd2, 2'd1, 1'b0, 1'b0, 9'h040, 4'd10, 12'h280, 12'h040},
        '{2'd3, 2'd0, 1'b0, 1'b1, 9'h155, 4'd11, 12'h6AA, 12'h255},
        '{2'd3, 2'd0, 1'b1, 1'b1, 9'h0FF, 4'd12, 12'hDFE, 12'h0FF},
        '{2'd1, 2'd2, 1'b0, 1'b0, 9'h0FF, 4'd9,  12'h17E, 12'h03F}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(input logic [8:0] v);
        @(negedge clk);
        tx_push = 1'b1;
        tx_data = v;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_rx();
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic send_serial(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            rxd_drv = bits[i];
            wait_clk(BIT);
        end
        rxd_drv = 1'b1;
    endtask

    task automatic capture(input int n, output logic [11:0] got);
        int guard;
        got   = '0;
        guard = 0;
        while (txd !== 1'b0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        wait_clk(BIT / 2);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            if (i < n - 1) wait_clk(BIT);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] got;
        wait_clk(5);
        // reset state (R8, R6, R10, R12)
        check("R8 txd idle high in reset", 32'(txd), 32'd1);
        check("R6 rx empty after reset", 32'(rx_empty), 32'd1);
        check("R6 tx not full after reset", 32'(tx_full), 32'd0);
        rst_n = 1'b1;
        wait_clk(5);
        check("R10 irq_rx low after reset", 32'(irq_rx), 32'd0);
        check("R12 irq_rto low after reset", 32'(irq_rto), 32'd0);

        // R11: empty transmit queue requests service only when enabled
        check("R11 irq_tx masked", 32'(irq_tx), 32'd0);
        cfg_irq_en = 3'b010;
        wait_clk(3);
        check("R11 irq_tx empty queue", 32'(irq_tx), 32'd1);
        cfg_irq_en = 3'b000;

        // vector table: frame on txd (R1 R2 R3 R4 R14) and loopback entry (R5)
        lb = 1'b1;
        for (int v = 0; v < 6; v++) begin
            cfg_wlen  = VEC[v].wl;
            cfg_par   = VEC[v].par;
            cfg_stop2 = VEC[v].s2;
            cfg_nine  = VEC[v].nine;
            wait_clk(2);
            push_tx(VEC[v].dat);
            capture(int'(VEC[v].len), got);
            check($sformatf("R1 R2 R3 R4 R14 frame vec%0d", v), 32'(got), 32'(VEC[v].frame));
            wait_clk(BIT * 2);
            check($sformatf("R5 entry present vec%0d", v), 32'(rx_empty), 32'd0);
            check($sformatf("R5 entry vec%0d", v), 32'(rx_data), 32'(VEC[v].ent));
            pop_rx();
            wait_clk(2);
        end
        lb = 1'b0;
        cfg_wlen = 2'd3; cfg_par = 2'd0; cfg_stop2 = 1'b0; cfg_nine = 1'b0;
        wait_clk(BIT * 2);

        // R8: break generation
        @(negedge clk) cfg_break = 1'b1;
        wait_clk(2);
        check("R8 break drives txd low", 32'(txd), 32'd0);
        @(negedge clk) cfg_break = 1'b0;
        wait_clk(3);
        check("R8 txd high after break", 32'(txd), 32'd1);

        // R2: parity error, 8E1 data 0x01 sent with wrong parity 0
        cfg_par = 2'd2;
        send_serial(16'h0402, 11);
        wait_clk(8);
        check("R2 parity error flagged", 32'(rx_data), 32'h201);
        pop_rx();
        cfg_par = 2'd0;

        // R3: framing error, data 0x5A with low stop bit
        send_serial(16'h00B4, 10);
        wait_clk(8);
        check("R3 framing error flagged", 32'(rx_data), 32'h45A);
        pop_rx();
        wait_clk(BIT);

        // R9: break detection, line low for 12 bits
        send_serial(16'h0000, 12);
        wait_clk(BIT);
        check("R9 break entry", 32'(rx_data), 32'h500);
        pop_rx();
        wait_clk(2);
        check("R9 single break entry", 32'(rx_empty), 32'd1);

        // R7: false start glitch then valid frame
        rxd_drv = 1'b0;
        wait_clk(6);
        rxd_drv = 1'b1;
        wait_clk(400);
        check("R7 glitch rejected", 32'(rx_empty), 32'd1);
        send_serial(16'h0278, 10);
        wait_clk(8);
        check("R7 receiver idle after glitch", 32'(rx_data), 32'h03C);

        // R12: timeout with one entry waiting
        wait_clk(780);
        check("R12 no timeout before 512 ticks", 32'(irq_rto), 32'd0);
        cfg_irq_en = 3'b100;
        wait_clk(320);
        check("R12 timeout raised", 32'(irq_rto), 32'd1);
        cfg_irq_en = 3'b000;
        wait_clk(3);
        check("R12 timeout masked", 32'(irq_rto), 32'd0);
        pop_rx();

        // R10: receive trigger threshold 1
        cfg_rx_trig = 4'd1;
        cfg_irq_en  = 3'b001;
        send_serial(16'h0202, 10);
        wait_clk(8);
        check("R10 level 1 not above trigger", 32'(irq_rx), 32'd0);
        send_serial(16'h0204, 10);
        wait_clk(8);
        check("R10 level 2 above trigger", 32'(irq_rx), 32'd1);
        check("R5 oldest entry first", 32'(rx_data), 32'h001);
        pop_rx();
        pop_rx();
        cfg_irq_en  = 3'b000;
        cfg_rx_trig = 4'd0;

        // R13, R6: 17 characters into a 16-deep receive queue
        lb = 1'b1;
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            tx_push = 1'b1;
            tx_data = 9'(8'h30 + i);
        end
        @(negedge clk) tx_push = 1'b0;
        wait_clk(BIT * 10 * 17 + BIT * 4);
        check("R6 first of 16", 32'(rx_data), 32'h030);
        for (int i = 0; i < 15; i++) pop_rx();
        check("R13 newest entry flagged", 32'(rx_data), 32'h83F);
        pop_rx();
        wait_clk(2);
        check("R13 extra character dropped", 32'(rx_empty), 32'd1);

        // R6, R13: queues off, one slot each
        cfg_fifo_en = 1'b0;
        wait_clk(2);
        @(negedge clk);
        tx_push = 1'b1; tx_data = 9'h011;
        @(negedge clk);
        tx_data = 9'h022;
        @(negedge clk);
        tx_push = 1'b0;
        wait_clk(2);
        check("R6 one-slot transmit full", 32'(tx_full), 32'd1);
        wait_clk(BIT * 10 * 2 + BIT * 2);
        check("R13 one-slot overrun", 32'(rx_data), 32'h811);
        pop_rx();
        wait_clk(2);
        check("R6 one-slot drained", 32'(rx_empty), 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule